// File: doc/BRIEF.md
# Direction-Steered Static Branch Predictor with Redirect and Flush Control

This block supplies the direction guess and fetch steering for a short in-order pipeline. While a branch sits in decode, the core presents whether the instruction is a branch, whether it is conditional, the sign of its displacement and its already computed target. The block guesses taken for every unconditional transfer (jumps, calls, returns) and for conditional branches that jump to a lower address. It guesses not-taken for conditional branches that jump forward. A taken guess steers fetch to the decode-stage target and squashes the single instruction fetched behind the branch, which costs one bubble. A not-taken guess costs nothing.

The core carries the guess down the pipe. When the branch reaches execute, the core hands back the guess, the resolved direction and the correct next PC. If the guess was wrong, the block steers fetch to that corrected PC and clears every stage between fetch and execute. The number of those stages is a parameter. A correction from execute always wins over a decode-stage redirect in the same cycle, because the decode instruction is then on the wrong path.

Three counters let a bench reconcile the penalty accounting: predictions made, mispredictions, and cycles in which any flush was raised.

Top module: `static_dir_predictor`

## Requirements
- R1: A valid conditional branch in decode with `dec_backward`=1 gives `pred_taken`=1 in the same cycle.
- R2: A valid conditional branch in decode with `dec_backward`=0 gives `pred_taken`=0, no redirect and `flush`=0.
- R3: A valid unconditional branch in decode (`dec_is_cond`=0) gives `pred_taken`=1 whatever the value of `dec_backward`.
- R4: A taken guess with no misprediction in the same cycle raises `redirect_valid`, drives `redirect_pc`=`dec_target` and sets only `flush[0]` (the fetch stage), all in the same cycle.
- R5: A valid execute branch whose `ex_pred_taken` differs from `ex_taken` raises `redirect_valid`, drives `redirect_pc`=`ex_next_pc` and sets every bit of `flush` (GAP bits, bit 0 being fetch), all in the same cycle.
- R6: When R5 applies in the same cycle as a decode branch, the outcome is exactly the R5 outcome. The decode branch is not counted as a prediction. `pred_taken` still reports the direction guess.
- R7: A valid execute branch whose guess matches its outcome causes no redirect and no flush.
- R8: An instruction that is not a valid branch (`*_valid`=0 or `*_is_branch`=0), in either stage, causes no redirect, no flush and no `pred_taken`.
- R9: `n_predicted`, `n_mispredicted` and `n_flush_cycles` start at 0 after reset. Each one counts up by one on the clock edge that ends a cycle with, respectively, a counted decode branch, a misprediction, or a nonzero `flush`.
- R10: While `rst_n` is low, with idle inputs, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode stage holds a valid instruction |
| dec_is_branch | input | 1 | Decode instruction is a control transfer |
| dec_is_cond | input | 1 | Decode branch is conditional |
| dec_backward | input | 1 | Displacement sign, 1 = target below branch |
| dec_target | input | PC_W | Target address computed in decode |
| ex_valid | input | 1 | Execute stage holds a valid instruction |
| ex_is_branch | input | 1 | Execute instruction is a control transfer |
| ex_pred_taken | input | 1 | Guess carried down with the branch |
| ex_taken | input | 1 | Resolved direction |
| ex_next_pc | input | PC_W | Correct next PC after the branch |
| pred_taken | output | 1 | Direction guess for the decode branch |
| redirect_valid | output | 1 | Fetch must restart at `redirect_pc` |
| redirect_pc | output | PC_W | Fetch restart address |
| flush | output | GAP | Per-stage squash, bit 0 = fetch |
| n_predicted | output | CNT_W | Counted predictions |
| n_mispredicted | output | CNT_W | Mispredictions |
| n_flush_cycles | output | CNT_W | Cycles with any flush bit set |

## Verification
On every cycle, the in-module assertions check the direction rules for unconditional and conditional branches, the full flush and corrected target on a mismatch, the single-bubble squash on a decode redirect, the quiet response to non-branches, and the one-step advance of the misprediction counter. The scenarios alone show the rest. They show that an execute correction overrides a decode redirect and suppresses its prediction count. They show that a matching guess stays silent, and that all three counters add up correctly over long mixed sequences, including cycles where both stages carry branches.

// File: rtl/static_dir_predictor.sv
`timescale 1ns/1ps
module static_dir_predictor #(
  parameter int PC_W  = 32,
  parameter int GAP   = 2,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_valid,
  input  logic             dec_is_branch,
  input  logic             dec_is_cond,
  input  logic             dec_backward,
  input  logic [PC_W-1:0]  dec_target,
  input  logic             ex_valid,
  input  logic             ex_is_branch,
  input  logic             ex_pred_taken,
  input  logic             ex_taken,
  input  logic [PC_W-1:0]  ex_next_pc,
  output logic             pred_taken,
  output logic             redirect_valid,
  output logic [PC_W-1:0]  redirect_pc,
  output logic [GAP-1:0]   flush,
  output logic [CNT_W-1:0] n_predicted,
  output logic [CNT_W-1:0] n_mispredicted,
  output logic [CNT_W-1:0] n_flush_cycles
);

  localparam logic [GAP-1:0] FLUSH_ALL    = {GAP{1'b1}};
  localparam logic [GAP-1:0] FLUSH_BUBBLE = GAP'(1);

  logic dec_br, ex_br, mispredict, dec_steer;

  assign dec_br     = dec_valid & dec_is_branch;
  assign ex_br      = ex_valid & ex_is_branch;
  assign mispredict = ex_br & (ex_pred_taken ^ ex_taken);
  assign pred_taken = dec_br & (~dec_is_cond | dec_backward);
  assign dec_steer  = pred_taken & ~mispredict;

  assign redirect_valid = mispredict | dec_steer;
  assign redirect_pc    = mispredict ? ex_next_pc :
                          dec_steer  ? dec_target : '0;
  assign flush          = mispredict ? FLUSH_ALL :
                          dec_steer  ? FLUSH_BUBBLE : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_predicted    <= '0;
      n_mispredicted <= '0;
      n_flush_cycles <= '0;
    end else begin
      if (dec_br && !mispredict) n_predicted    <= n_predicted + CNT_W'(1);
      if (mispredict)            n_mispredicted <= n_mispredicted + CNT_W'(1);
      if (|flush)                n_flush_cycles <= n_flush_cycles + CNT_W'(1);
    end
  end

  // R3: unconditional transfers are always guessed taken
  a_r3_uncond_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_is_branch && !dec_is_cond) |-> pred_taken);

  // R1 / R2: conditional guess follows displacement sign
  a_r1_backward_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_is_branch && dec_is_cond) |-> (pred_taken == dec_backward));

  // R5: mismatch clears every stage and restarts at the corrected PC
  a_r5_mispredict_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_is_branch && (ex_pred_taken != ex_taken))
      |-> (redirect_valid && redirect_pc == ex_next_pc && flush == FLUSH_ALL));

  // R4: decode redirect costs exactly one squashed slot
  a_r4_one_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_taken && !(ex_valid && ex_is_branch && (ex_pred_taken != ex_taken)))
      |-> (flush == FLUSH_BUBBLE && redirect_pc == dec_target));

  // R8: no branch anywhere means no steering
  a_r8_nonbranch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!(dec_valid && dec_is_branch) && !(ex_valid && ex_is_branch))
      |-> (!redirect_valid && flush == '0 && !pred_taken));

  // R9: misprediction counter advances by one
  a_r9_mispred_count: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_is_branch && (ex_pred_taken != ex_taken))
      |=> (n_mispredicted == $past(n_mispredicted) + CNT_W'(1)));

endmodule

// File: tb/tb_static_dir_predictor.sv
`timescale 1ns/1ps
module tb_static_dir_predictor;
  localparam int PC_W = 32, GAP = 2, CNT_W = 16;

  logic clk = 0, rst_n = 0;
  logic dec_valid = 0, dec_is_branch = 0, dec_is_cond = 0, dec_backward = 0;
  logic [PC_W-1:0] dec_target = '0;
  logic ex_valid = 0, ex_is_branch = 0, ex_pred_taken = 0, ex_taken = 0;
  logic [PC_W-1:0] ex_next_pc = '0;
  logic pred_taken, redirect_valid;
  logic [PC_W-1:0] redirect_pc;
  logic [GAP-1:0] flush;
  logic [CNT_W-1:0] n_predicted, n_mispredicted, n_flush_cycles;

  static_dir_predictor #(.PC_W(PC_W), .GAP(GAP), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .dec_valid(dec_valid), .dec_is_branch(dec_is_branch), .dec_is_cond(dec_is_cond),
    .dec_backward(dec_backward), .dec_target(dec_target),
    .ex_valid(ex_valid), .ex_is_branch(ex_is_branch), .ex_pred_taken(ex_pred_taken),
    .ex_taken(ex_taken), .ex_next_pc(ex_next_pc),
    .pred_taken(pred_taken), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .flush(flush), .n_predicted(n_predicted), .n_mispredicted(n_mispredicted),
    .n_flush_cycles(n_flush_cycles));

  always #2 clk = ~clk;

  typedef struct packed {
    logic pt;
    logic rv;
    logic [PC_W-1:0] pc;
    logic [GAP-1:0] fl;
    logic [CNT_W-1:0] np, nm, nf;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int tests = 0, fails = 0;
  int tot_p = 0, tot_m = 0, tot_f = 0;
  bit done = 0;

  task automatic chk(input string tag, input string what, input longint act, input longint expv);
    tests++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, expv);
    end
  endtask

  task automatic drive(input logic dv, input logic db, input logic dc, input logic dk,
                       input logic [PC_W-1:0] dt,
                       input logic ev, input logic eb, input logic ep, input logic et,
                       input logic [PC_W-1:0] en, input string tag);
    exp_t e;
    logic dbr, mis, guess, steer;
    @(posedge clk); #1;
    dec_valid = dv; dec_is_branch = db; dec_is_cond = dc; dec_backward = dk; dec_target = dt;
    ex_valid = ev; ex_is_branch = eb; ex_pred_taken = ep; ex_taken = et; ex_next_pc = en;
    dbr   = dv && db;
    mis   = ev && eb && (ep != et);
    guess = dbr && (!dc || dk);
    steer = guess && !mis;
    e.pt = guess;
    e.rv = mis || steer;
    e.pc = mis ? en : (steer ? dt : '0);
    e.fl = mis ? {GAP{1'b1}} : (steer ? GAP'(1) : '0);
    e.np = CNT_W'(tot_p); e.nm = CNT_W'(tot_m); e.nf = CNT_W'(tot_f);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    if (dbr && !mis) tot_p++;
    if (mis) tot_m++;
    if (e.fl != '0) tot_f++;
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, "pred_taken", pred_taken, e.pt);
        chk(t, "redirect_valid", redirect_valid, e.rv);
        chk(t, "redirect_pc", redirect_pc, e.pc);
        chk(t, "flush", flush, e.fl);
        chk({t, "/R9"}, "n_predicted", n_predicted, e.np);
        chk({t, "/R9"}, "n_mispredicted", n_mispredicted, e.nm);
        chk({t, "/R9"}, "n_flush_cycles", n_flush_cycles, e.nf);
      end
    end
  end

  initial begin : watchdog
    #80000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] lfsr;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10", "redirect_valid", redirect_valid, 0);
    chk("R10", "flush", flush, 0);
    chk("R10", "pred_taken", pred_taken, 0);
    chk("R10", "counters", {n_predicted, n_mispredicted, n_flush_cycles}, 0);
    @(posedge clk); #1 rst_n = 1;

    drive(1,1,1,1,32'h0000_0100, 0,0,0,0,'0, "R1_backward_cond");
    drive(1,1,1,0,32'h0000_0200, 0,0,0,0,'0, "R2_forward_cond");
    drive(1,1,0,0,32'h0000_0300, 0,0,0,0,'0, "R3_uncond_fwd");
    drive(1,1,0,1,32'h0000_0040, 0,0,0,0,'0, "R3_uncond_back_R4");
    drive(1,0,1,1,32'h0000_0500, 0,0,0,0,'0, "R8_dec_nonbranch");
    drive(0,1,0,1,32'h0000_0600, 0,0,0,0,'0, "R8_dec_invalid");
    drive(0,0,0,0,'0, 1,1,1,1,32'h0000_0700, "R7_match_taken");
    drive(0,0,0,0,'0, 1,1,0,0,32'h0000_0704, "R7_match_nottaken");
    drive(0,0,0,0,'0, 1,1,0,1,32'h0000_0800, "R5_late_taken");
    drive(0,0,0,0,'0, 1,1,1,0,32'h0000_0904, "R5_late_nottaken");
    drive(1,1,1,1,32'h0000_0A00, 1,1,0,1,32'h0000_0B00, "R6_ex_wins_dec_taken");
    drive(1,1,1,0,32'h0000_0C00, 1,1,1,0,32'h0000_0D00, "R6_ex_wins_dec_fwd");
    drive(0,0,0,0,'0, 1,0,1,0,32'h0000_0E00, "R8_ex_nonbranch");
    drive(0,0,0,0,'0, 0,1,0,1,32'h0000_0F00, "R8_ex_invalid");
    drive(1,1,1,0,32'h0000_1000, 1,1,1,1,32'h0000_1100, "R7_R2_both_quiet");

    lfsr = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      drive(lfsr[0], lfsr[1], lfsr[2], lfsr[3], {16'h0, lfsr},
            lfsr[4], lfsr[5], lfsr[6], lfsr[7], {lfsr, 16'h0}, "R9_mixed");
    end
    drive(0,0,0,0,'0, 0,0,0,0,'0, "R9_final_totals");
    @(posedge clk);
    @(negedge clk); #1;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule